// File: doc/BRIEF.md
# Serial EEPROM Read Sequencer

This block sits behind the byte-level front end of a two-wire serial memory slave. It holds the one address counter shared by the array, recognises the device select byte, and serves every read flavour. A plain read select returns the byte under the counter. A write-direction select followed by one address byte loads the counter and writes nothing, so a repeated start with a read select turns it into a random read. A master acknowledge keeps a sequential stream going.

The front end decodes start and stop conditions, collects bytes, samples the master's acknowledge bit and shifts data out. It reports these to this block as one-cycle pulses on the system clock. The sequencer answers with an acknowledge request for the byte just received, and with the next data byte to shift out. It fetches that byte from an array read port with combinational data, one clock after the event that asks for it. Write buffering and the programming cycle belong to other blocks.

The counter is `ADDR_W` bits wide, from 7 to 11. When `ADDR_W` exceeds 8, the low `ADDR_W-8` chip bits of the select byte carry the upper address bits and are not compared with the chip identity.

Top module: `eeprom_read_seq`

## Requirements
- R1: While reset is asserted and right after it, `rx_ack` and `tx_valid` are 0 and `mem_addr` is 0.
- R2: The block treats a select byte received right after a start as its own only if bits 7:4 equal 1010 and the chip bits 3:1 not used for addressing equal `chip_id`. Bit 0 set means read. A foreign select gets no `rx_ack`, and every byte up to the next start is ignored.
- R3: After a matching select with bit 0 clear, the next byte is acknowledged and loaded into the counter. Its 8 bits form the low address bits, and select bits 1 upward supply any higher address bits. No data is written.
- R4: A matching read select that does not follow an address load is acknowledged. One clock later `tx_byte` holds the array byte at the counter, `tx_valid` is 1, and the counter has advanced by one.
- R5: After an address load, a repeated start followed by a read select whose bits 7:1 equal those of the write select returns the byte at the loaded address.
- R6: After an address load, a repeated-start read select whose bits 7:1 differ from the write select gets no `rx_ack` and produces no data.
- R7: During a read, a master acknowledge with the bit low fetches the byte at the counter and advances the counter. With the bit high, the block drops `tx_valid` and returns to standby.
- R8: A sequential read wraps from the last array address to address 0.
- R9: A stop or a new start during a read drops `tx_valid` at once. The counter keeps every increment already made.
- R10: Bytes that follow the address byte of a write are neither acknowledged by this block nor allowed to move the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_id | input | 3 | Strapped chip identity compared with select bits 3:1 |
| bus_start | input | 1 | Pulse: start or repeated start seen |
| bus_stop | input | 1 | Pulse: stop seen |
| rx_valid | input | 1 | Pulse: a byte from the master is complete |
| rx_byte | input | 8 | The received byte, valid with `rx_valid` |
| ack_valid | input | 1 | Pulse: the master's acknowledge bit after a read byte was sampled |
| ack_low | input | 1 | That bit was low (continue) |
| mem_rdata | input | 8 | Array data at `mem_addr`, combinational |
| rx_ack | output | 1 | One-cycle request to acknowledge the byte just received |
| mem_addr | output | ADDR_W | Current address counter, also the array read address |
| tx_byte | output | 8 | Byte to shift out to the master |
| tx_valid | output | 1 | The block is driving read data |

## Verification
A counter that skips or stalls appears on `mem_addr` in the clock after the fetch that moved it. The byte on `tx_byte` then disagrees with the model array value in that same clock. A sequencer stuck in the wrong state appears as a missing or extra `rx_ack` one clock after the select or address byte. It also appears as `tx_valid` staying high after a not-acknowledge, a stop or a start. A lost address load is visible one clock after the address byte, because `mem_addr` must equal the loaded value before any read is issued.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_SEL,
    RS_ADDR,
    RS_WDATA,
    RS_READ
  } rs_state_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  // number of select bits that carry address instead of chip identity
  function automatic int sel_addr_bits(input int aw);
    return (aw > 8) ? (aw - 8) : 0;
  endfunction

endpackage

// File: rtl/eerd_sel_match.sv
module eerd_sel_match #(
  parameter int ADDR_W = 9
) (
  input  logic [7:0] sel_byte,
  input  logic [2:0] chip_id,
  input  logic [6:0] first_sel,
  output logic       dev_hit,
  output logic       same_hit
);
  import eerd_pkg::*;

  localparam int        HI_W    = sel_addr_bits(ADDR_W);
  localparam logic [2:0] ID_MASK = 3'b111 << HI_W;

  always_comb begin
    dev_hit  = (sel_byte[7:4] == DEV_TYPE) &&
               (((sel_byte[3:1] ^ chip_id) & ID_MASK) == 3'b000);
    same_hit = (sel_byte[7:1] == first_sel);
  end

endmodule

// File: rtl/eerd_addr_ctr.sv
module eerd_addr_ctr #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] cnt
);

  logic [ADDR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load || inc)  cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // the sequencer never loads and advances in one cycle (R3, R4)
  assert_load_inc_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && inc));

endmodule

// File: rtl/eeprom_read_seq.sv
module eeprom_read_seq #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        chip_id,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              ack_valid,
  input  logic              ack_low,
  input  logic [7:0]        mem_rdata,
  output logic              rx_ack,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        tx_byte,
  output logic              tx_valid
);
  import eerd_pkg::*;

  localparam int HI_W = sel_addr_bits(ADDR_W);

  rs_state_e         st_q, st_d;
  logic              loaded_q, loaded_d;
  logic [6:0]        first_q, first_d;
  logic              ack_q, ack_d;
  logic              txv_q, txv_d;
  logic [7:0]        txb_q;
  logic              dev_hit, same_hit;
  logic              fetch, load;
  logic [ADDR_W-1:0] load_val, cnt;

  eerd_sel_match #(.ADDR_W(ADDR_W)) u_match (
    .sel_byte (rx_byte),
    .chip_id  (chip_id),
    .first_sel(first_q),
    .dev_hit  (dev_hit),
    .same_hit (same_hit)
  );

  generate
    if (HI_W > 0) begin : g_hi_addr
      assign load_val = {first_q[HI_W-1:0], rx_byte};
    end else begin : g_lo_addr
      assign load_val = rx_byte[ADDR_W-1:0];
    end
  endgenerate

  eerd_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .load_val(load_val),
    .inc     (fetch),
    .cnt     (cnt)
  );

  // next-state
  always_comb begin
    st_d     = st_q;
    loaded_d = loaded_q;
    first_d  = first_q;
    ack_d    = 1'b0;
    txv_d    = txv_q;
    fetch    = 1'b0;
    load     = 1'b0;
    if (bus_stop) begin
      st_d     = RS_IDLE;
      txv_d    = 1'b0;
      loaded_d = 1'b0;
    end else if (bus_start) begin
      st_d     = RS_SEL;
      txv_d    = 1'b0;
      loaded_d = (st_q == RS_WDATA);
    end else begin
      case (st_q)
        RS_SEL: if (rx_valid) begin
          if (!dev_hit) begin
            st_d = RS_IDLE;
          end else if (!rx_byte[0]) begin
            first_d = rx_byte[7:1];
            ack_d   = 1'b1;
            st_d    = RS_ADDR;
          end else if (!loaded_q || same_hit) begin
            ack_d    = 1'b1;
            fetch    = 1'b1;
            txv_d    = 1'b1;
            loaded_d = 1'b0;
            st_d     = RS_READ;
          end else begin
            st_d = RS_IDLE;
          end
        end
        RS_ADDR: if (rx_valid) begin
          load     = 1'b1;
          ack_d    = 1'b1;
          loaded_d = 1'b1;
          st_d     = RS_WDATA;
        end
        RS_READ: if (ack_valid) begin
          if (ack_low) begin
            fetch = 1'b1;
          end else begin
            txv_d = 1'b0;
            st_d  = RS_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= RS_IDLE;
      loaded_q <= 1'b0;
      first_q  <= '0;
      ack_q    <= 1'b0;
      txv_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      loaded_q <= loaded_d;
      first_q  <= first_d;
      ack_q    <= ack_d;
      txv_q    <= txv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     txb_q <= '0;
    else if (fetch) txb_q <= mem_rdata;
  end

  assign rx_ack   = ack_q;
  assign tx_valid = txv_q;
  assign tx_byte  = txb_q;
  assign mem_addr = cnt;

  // ---------------- assertions ----------------
  assert_ack_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack |-> $past(rx_valid));

  assert_addr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RS_ADDR && rx_valid && !bus_start && !bus_stop) |=> (rx_ack && !tx_valid));

  assert_fetch_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)) && tx_valid);

  assert_noack_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RS_READ && ack_valid && !ack_low && !bus_start && !bus_stop) |=> !tx_valid);

  assert_wrap_to_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && mem_addr == '1) |=> (mem_addr == '0));

  assert_stop_silences_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> (!tx_valid && !rx_ack && $stable(mem_addr)));

  assert_wdata_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RS_WDATA && rx_valid && !bus_start && !bus_stop) |=> (!rx_ack && $stable(mem_addr)));

endmodule

// File: tb/eeprom_read_seq_bench.sv
`timescale 1ns/1ps
module eeprom_read_seq_bench;

  localparam int AW = 9;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    chip_id;
  logic          bus_start, bus_stop, rx_valid, ack_valid, ack_low;
  logic [7:0]    rx_byte, mem_rdata, tx_byte;
  logic          rx_ack, tx_valid;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit started = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  function automatic int memv(input int a);
    return (a * 37 + 11) % 256;
  endfunction

  assign mem_rdata = 8'(memv(int'(mem_addr)));

  eeprom_read_seq #(.ADDR_W(AW)) u_eeprom_read_seq (
    .clk(clk), .rst_n(rst_n), .chip_id(chip_id),
    .bus_start(bus_start), .bus_stop(bus_stop),
    .rx_valid(rx_valid), .rx_byte(rx_byte),
    .ack_valid(ack_valid), .ack_low(ack_low),
    .mem_rdata(mem_rdata), .rx_ack(rx_ack), .mem_addr(mem_addr),
    .tx_byte(tx_byte), .tx_valid(tx_valid)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 idle, 1 select, 2 address, 3 write data, 4 reading
  int m_phase = 0, m_cnt = 0, m_first = 0, m_txb = 0;
  bit m_loaded = 0, m_ack = 0, m_txv = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_first = 0; m_txb = 0;
      m_loaded = 0; m_ack = 0; m_txv = 0;
    end else begin
      m_ack = 0;
      if (bus_stop) begin
        m_phase = 0; m_txv = 0; m_loaded = 0;
      end else if (bus_start) begin
        m_loaded = (m_phase == 3);
        m_phase = 1; m_txv = 0;
      end else if (m_phase == 1 && rx_valid) begin
        // select: type 1010, chip bits 3:2 compared (bit 1 is address bit 8)
        if (rx_byte[7:4] != 4'hA || rx_byte[3:2] != chip_id[2:1]) m_phase = 0;
        else if (rx_byte[0] == 0) begin
          m_first = int'(rx_byte) / 2; m_ack = 1; m_phase = 2;
        end else if (!m_loaded || int'(rx_byte) / 2 == m_first) begin
          m_ack = 1; m_txb = memv(m_cnt); m_cnt = (m_cnt + 1) % DEPTH;
          m_txv = 1; m_loaded = 0; m_phase = 4;
        end else m_phase = 0;
      end else if (m_phase == 2 && rx_valid) begin
        m_cnt = ((m_first % 2) * 256 + int'(rx_byte)) % DEPTH;
        m_ack = 1; m_loaded = 1; m_phase = 3;
      end else if (m_phase == 4 && ack_valid) begin
        if (ack_low) begin
          m_txb = memv(m_cnt); m_cnt = (m_cnt + 1) % DEPTH;
        end else begin
          m_txv = 0; m_phase = 0;
        end
      end
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      check(cur_req, int'(rx_ack),   int'(m_ack), "rx_ack");
      check(cur_req, int'(tx_valid), int'(m_txv), "tx_valid");
      check(cur_req, int'(mem_addr), m_cnt,       "mem_addr");
      if (m_txv) check(cur_req, int'(tx_byte), m_txb, "tx_byte");
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic do_start();
    @(negedge clk); bus_start = 1; @(negedge clk); bus_start = 0;
  endtask
  task automatic do_stop();
    @(negedge clk); bus_stop = 1; @(negedge clk); bus_stop = 0;
  endtask
  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b; @(negedge clk); rx_valid = 0;
  endtask
  task automatic mack(input logic low);
    @(negedge clk); ack_valid = 1; ack_low = low; @(negedge clk); ack_valid = 0;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    rst_n = 0; chip_id = 3'b101;
    bus_start = 0; bus_stop = 0; rx_valid = 0; rx_byte = 0; ack_valid = 0; ack_low = 0;
    idle(3);
    check("R1", int'(tx_valid), 0, "tx_valid in reset");
    check("R1", int'(mem_addr), 0, "mem_addr in reset");
    rst_n = 1;
    idle(2);
    check("R1", int'(rx_ack), 0, "rx_ack after reset");

    // R4 current-address read, then R7 continue and stop
    cur_req = "R4";
    do_start(); send(8'hA9);
    check("R4", int'(tx_byte), memv(0), "first byte");
    check("R4", int'(mem_addr), 1, "counter after read");
    cur_req = "R7";
    mack(1'b1);
    check("R7", int'(tx_byte), memv(1), "next byte on ack low");
    mack(1'b0);
    check("R7", int'(tx_valid), 0, "released on no-ack");
    send(8'hA9);
    check("R7", int'(rx_ack), 0, "standby ignores bytes");
    do_stop(); idle(2);

    // R2 foreign selects
    cur_req = "R2";
    do_start(); send(8'hB1);
    check("R2", int'(rx_ack), 0, "wrong type");
    send(8'hA9);
    check("R2", int'(rx_ack), 0, "ignored until start");
    do_start(); send(8'hA5);
    check("R2", int'(rx_ack), 0, "wrong chip bits");
    do_stop();

    // R3 + R5 random read at 0x134
    cur_req = "R3";
    do_start(); send(8'hAA); send(8'h34);
    check("R3", int'(mem_addr), 9'h134, "loaded address");
    cur_req = "R5";
    do_start(); send(8'hAB);
    check("R5", int'(rx_ack), 1, "repeat select acked");
    check("R5", int'(tx_byte), memv(9'h134), "random byte");
    mack(1'b0); do_stop();

    // R6 mismatched repeated select
    cur_req = "R6";
    do_start(); send(8'hAA); send(8'h10);
    do_start(); send(8'hA9);
    check("R6", int'(rx_ack), 0, "mismatch not acked");
    check("R6", int'(tx_valid), 0, "no data");
    do_stop();

    // R10 write data bytes ignored
    cur_req = "R10";
    do_start(); send(8'hA8); send(8'h05); send(8'h77);
    check("R10", int'(rx_ack), 0, "data byte not acked");
    check("R10", int'(mem_addr), 5, "counter unmoved");
    do_stop();

    // R8 wrap, then R9 stop abort
    cur_req = "R8";
    do_start(); send(8'hAA); send(8'hFE);
    do_start(); send(8'hAB);
    check("R8", int'(tx_byte), memv(9'h1FE), "byte 1FE");
    mack(1'b1);
    check("R8", int'(tx_byte), memv(9'h1FF), "byte 1FF");
    mack(1'b1);
    check("R8", int'(tx_byte), memv(0), "wrapped byte 0");
    check("R8", int'(mem_addr), 1, "counter after wrap");
    cur_req = "R9";
    do_stop();
    check("R9", int'(tx_valid), 0, "stop aborts");
    check("R9", int'(mem_addr), 1, "counter kept");
    do_start(); send(8'hA9);
    check("R9", int'(tx_byte), memv(1), "resume at kept counter");
    mack(1'b1);
    do_start();
    check("R9", int'(tx_valid), 0, "start aborts");
    check("R9", int'(mem_addr), 3, "counter kept after start");
    do_stop(); idle(3);

    done = 1;
    finish_up();
  end

endmodule